// File: doc/BRIEF.md
# Pseudo-Carry Lookahead Adder

This block adds two unsigned operands of `W` bits. It produces the `W`-bit sum and the carry-out. The carry network does not evaluate the true carry at each position. It evaluates a pseudo-carry instead, whose recurrence links bit i to the transmit signal of bit i-1 rather than of bit i. Because of that shifted index, every group equation is one literal shorter than the matching conventional lookahead term. The true carry into a bit is rebuilt with a single AND: the pseudo-carry of the previous bit is ANDed with that bit's transmit signal. The sum bit is the half-sum XOR that rebuilt carry.

Each bit has three signals: generate g = a AND b, transmit t = a OR b and half-sum p = a XOR b. The pseudo-carry network is split into groups of `RADIX` bits, with `RADIX` set to 2 or 4. Inside a group the pseudo-carries come from flat sum-of-products terms. A group takes the pseudo-carry from the top of the group below it. That value is gated by a prefix product of transmit signals, and the prefix starts at the bit just under the group. `W` must be a multiple of `RADIX`.

The adder has no carry-in. The sum and carry-out are registered, and a synchronous active-high reset clears them. A result appears one clock edge after its operands are sampled.

Top module: `pcarry_adder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `sum_q` and `cout_q` become 0 at that edge, whatever the operands are.
- R2: Operands present at a rising edge with `rst` low are reflected in `sum_q`/`cout_q` right after that edge, and not before it.
- R3: `sum_q` equals the low `W` bits of the unsigned sum `opa + opb` sampled at the previous edge.
- R4: `cout_q` equals bit `W` of the unsigned sum `opa + opb`, i.e. it is 1 exactly when the sum overflows `W` bits.
- R5: There is no carry into bit 0. Adding 0 to 0 gives `sum_q` = 0 and `cout_q` = 0, and bit 0 of the sum is always `opa[0] XOR opb[0]`.
- R6: A carry born at bit 0 propagates through every group boundary. All-ones plus 1 gives `sum_q` = 0 and `cout_q` = 1. Operands whose bits are complementary at every position give an all-ones sum and no carry-out.
- R7: The results are identical for `RADIX` = 2 and `RADIX` = 4 at the same width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| opa | input | W | First unsigned operand |
| opb | input | W | Second unsigned operand |
| sum_q | output | W | Registered sum, low W bits |
| cout_q | output | 1 | Registered carry-out |

## Verification
The hardest corner is the pseudo-carry crossing a group boundary. If a design took the transmit product from bit i instead of bit i-1, or dropped the bit just under a group from the prefix, a carry rippling out of a full 4-bit or 2-bit group would be lost or invented. The exhaustive 8-bit sweep on both radix variants would then show a wrong sum in the bit above the boundary. The all-ones-plus-one and complementary patterns at 32 bits stress the longest chain. A design that used the pseudo-carry directly as the carry would give a wrong sum whenever a bit has a pseudo-carry but no transmit. A design that mishandled the missing carry-in would corrupt bit 0 on the zero case. The reset checks and the check made before the edge catch a result register that ignores reset or that passes results through early.

// File: rtl/pca_pkg.sv
package pca_pkg;

  // Number of lookahead groups for a given width and radix.
  function automatic int unsigned grp_count(input int unsigned width, input int unsigned radix);
    return (width + radix - 1) / radix;
  endfunction

  // Per-bit setup signals.
  typedef struct packed {
    logic gen;
    logic xmit;
    logic half;
  } bit_sig_t;

endpackage

// File: rtl/pca_bit_prep.sv
module pca_bit_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] gen,
  output logic [W-1:0] xmit,
  output logic [W-1:0] half
);
  import pca_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    bit_sig_t s;
    always_comb begin
      s.gen  = opa[i] & opb[i];
      s.xmit = opa[i] | opb[i];
      s.half = opa[i] ^ opb[i];
    end
    assign gen[i]  = s.gen;
    assign xmit[i] = s.xmit;
    assign half[i] = s.half;
  end

endmodule

// File: rtl/pca_group.sv
module pca_group #(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] gen,
  input  logic [K-1:0] xmit,
  input  logic         xmit_below,  // transmit of the bit just under this group
  input  logic         h_in,        // pseudo-carry of the bit just under this group
  output logic [K-1:0] h_out
);

  logic [K-1:0] h_loc;   // pseudo-carries with no input from below
  logic [K-1:0] t_pre;   // transmit prefix products starting at the bit below

  if (K == 4) begin : g_r4
    // Flat radix-4 terms; g implies t, so the t on a generated bit drops out.
    always_comb begin
      h_loc[0] = gen[0];
      h_loc[1] = gen[1] | gen[0];
      h_loc[2] = gen[2] | gen[1] | (xmit[1] & gen[0]);
      h_loc[3] = gen[3] | gen[2] | (xmit[2] & gen[1]) | (xmit[2] & xmit[1] & gen[0]);
    end
  end else begin : g_rn
    always_comb begin
      h_loc[0] = gen[0];
      for (int j = 1; j < K; j++) begin
        h_loc[j] = gen[j] | (xmit[j-1] & h_loc[j-1]);
      end
    end
  end

  always_comb begin
    t_pre[0] = xmit_below;
    for (int j = 1; j < K; j++) begin
      t_pre[j] = t_pre[j-1] & xmit[j-1];
    end
  end

  for (genvar j = 0; j < K; j++) begin : g_out
    assign h_out[j] = h_loc[j] | (t_pre[j] & h_in);
  end

endmodule

// File: rtl/pca_pseudo_carry.sv
module pca_pseudo_carry #(
  parameter int unsigned W     = 32,
  parameter int unsigned RADIX = 4
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] xmit,
  output logic [W-1:0] hcar
);
  import pca_pkg::*;

  localparam int unsigned NG = grp_count(W, RADIX);

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int unsigned BASE = k * RADIX;
    logic t_below;
    logic h_below;
    if (k == 0) begin : g_first
      assign t_below = 1'b0;
      assign h_below = 1'b0;
    end else begin : g_next
      assign t_below = xmit[BASE-1];
      assign h_below = hcar[BASE-1];
    end
    pca_group #(.K(RADIX)) u_grp (
      .gen       (gen[BASE +: RADIX]),
      .xmit      (xmit[BASE +: RADIX]),
      .xmit_below(t_below),
      .h_in      (h_below),
      .h_out     (hcar[BASE +: RADIX])
    );
  end

endmodule

// File: rtl/pca_sum.sv
module pca_sum #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] half,
  input  logic [W-1:0] xmit,
  input  logic [W-1:0] hcar,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;  // true carry into each position

  assign carry[0] = 1'b0;
  for (genvar i = 1; i <= W; i++) begin : g_car
    assign carry[i] = xmit[i-1] & hcar[i-1];
  end

  assign sum  = half ^ carry[W-1:0];
  assign cout = carry[W];

endmodule

// File: rtl/pcarry_adder.sv
module pcarry_adder #(
  parameter int unsigned W     = 32,
  parameter int unsigned RADIX = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum_q,
  output logic         cout_q
);

  logic [W-1:0] gen, xmit, half, hcar, sum_c;
  logic         cout_c;

  pca_bit_prep #(.W(W)) u_prep (
    .opa (opa),
    .opb (opb),
    .gen (gen),
    .xmit(xmit),
    .half(half)
  );

  pca_pseudo_carry #(.W(W), .RADIX(RADIX)) u_hc (
    .gen (gen),
    .xmit(xmit),
    .hcar(hcar)
  );

  pca_sum #(.W(W)) u_sum (
    .half(half),
    .xmit(xmit),
    .hcar(hcar),
    .sum (sum_c),
    .cout(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_c;
      cout_q <= cout_c;
    end
  end

endmodule

// File: rtl/pcarry_adder_chk.sv
module pcarry_adder_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] sum_q,
  input logic         cout_q
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q)); // R1

  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_q == W'({1'b0, $past(opa)} + {1'b0, $past(opb)})); // R3

  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cout_q == (({1'b0, $past(opa)} + {1'b0, $past(opb)}) >> W)); // R4

  AST_NO_CARRY_IN: assert property (@(posedge clk) disable iff (rst)
    (opa == '0 && opb == '0) |=> (sum_q == '0 && !cout_q)); // R5

  AST_LOW_BIT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_q[0] == ($past(opa[0]) ^ $past(opb[0]))); // R5

  AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (&(opa ^ opb)) |=> (&sum_q && !cout_q)); // R6

endmodule

bind pcarry_adder pcarry_adder_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .opa   (opa),
  .opb   (opb),
  .sum_q (sum_q),
  .cout_q(cout_q)
);

// File: tb/pcarry_adder_tb.sv
`timescale 1ns/1ps
module pcarry_adder_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic [31:0] a32, b32;
  logic [31:0] s32;
  logic        c32;
  logic [7:0]  a8, b8;
  logic [7:0]  s8r4, s8r2;
  logic        c8r4, c8r2;

  int total = 0;
  int bad   = 0;

  pcarry_adder #(.W(32), .RADIX(4)) u_dut (
    .clk(clk), .rst(rst), .opa(a32), .opb(b32), .sum_q(s32), .cout_q(c32));
  pcarry_adder #(.W(8), .RADIX(4)) u_dut_w8r4 (
    .clk(clk), .rst(rst), .opa(a8), .opb(b8), .sum_q(s8r4), .cout_q(c8r4));
  pcarry_adder #(.W(8), .RADIX(2)) u_dut_w8r2 (
    .clk(clk), .rst(rst), .opa(a8), .opb(b8), .sum_q(s8r2), .cout_q(c8r2));

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a32 = '1; b32 = '1; a8 = '1; b8 = '1;
    repeat (3) @(negedge clk);
    chk("R1 sum32", {1'b0, s32}, 33'd0);
    chk("R1 cout32", {32'b0, c32}, 33'd0);
    chk("R1 r4 w8", {24'b0, c8r4, s8r4}, 33'd0);
    chk("R1 r2 w8", {24'b0, c8r2, s8r2}, 33'd0);
    rst = 1'b0;
  endtask

  task automatic t_exhaustive8();
    logic [8:0] exp;
    exp = '0;
    for (int i = 0; i <= 65536; i++) begin
      if (i > 0) begin
        chk("R3 R4 r4 w8", {24'b0, c8r4, s8r4}, {24'b0, exp});
        chk("R7 r2 w8", {24'b0, c8r2, s8r2}, {24'b0, exp});
      end
      if (i < 65536) begin
        a8 = 8'(i >> 8);
        b8 = 8'(i);
        exp = {1'b0, a8} + {1'b0, b8};
      end
      @(negedge clk);
    end
  endtask

  task automatic drive32(input logic [31:0] x, input logic [31:0] y, input string req);
    logic [32:0] exp;
    a32 = x; b32 = y;
    exp = {1'b0, x} + {1'b0, y};
    @(negedge clk);
    chk(req, {c32, s32}, exp);
  endtask

  task automatic t_random32();
    for (int n = 0; n < 3000; n++) begin
      drive32($urandom, $urandom, "R3 R4 rand32");
    end
  endtask

  task automatic t_corners32();
    drive32(32'h0, 32'h0, "R5 zero");
    drive32(32'h0000_0001, 32'h0000_0000, "R5 bit0");
    drive32(32'hFFFF_FFFF, 32'h0000_0001, "R6 allones+1");
    drive32(32'h0000_0001, 32'hFFFF_FFFF, "R6 1+allones");
    drive32(32'hAAAA_AAAA, 32'h5555_5555, "R6 complementary");
    drive32(32'h0000_000F, 32'h0000_0001, "R3 group edge");
    drive32(32'h0000_00FF, 32'h0000_0001, "R3 two groups");
    drive32(32'h7FFF_FFFF, 32'h0000_0001, "R3 into msb");
    drive32(32'h8000_0000, 32'h8000_0000, "R4 top gen");
    drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 all gen");
    drive32(32'h0F0F_0F0F, 32'h00F1_F0F1, "R3 mixed");
  endtask

  task automatic t_latency();
    drive32(32'd10, 32'd20, "R2 setup");
    a32 = 32'd5; b32 = 32'd7;
    #1;
    chk("R2 before edge", {c32, s32}, 33'd30);
    @(negedge clk);
    chk("R2 after edge", {c32, s32}, 33'd12);
  endtask

  task automatic t_reset_mid();
    a32 = 32'hFFFF_FFFF; b32 = 32'h0000_0001;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset", {c32, s32}, 33'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {c32, s32}, 33'h1_0000_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_exhaustive8();
    t_corners32();
    t_random32();
    t_latency();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule